// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns parallel characters into a serial line stream. A character enters a one-deep holding register through a write strobe. When the shift stage is free and transmission is enabled, the character moves into the shift stage and goes out on the line. The line carries a low start bit, then 8 or 9 data bits with the least significant bit first, then an optional odd or even parity bit, then one or two high stop bits. The line rests high between frames.

A baud tick input sets the pace, and one bit lasts sixteen ticks. Two flags report progress. One says the holding register can take a new character. The other says everything has drained and the line is back at rest. A break request holds the line low for one full character time, which is 10 or 11 bit times depending on the character length. The break starts once any frame already in flight has finished, and it goes out ahead of any character still waiting in the holding register.

Top module: `async_tx_break`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1. Whenever no frame or break is in flight, `txd` is 1.
- R2: A frame starts with one 0 bit. The data follows least significant bit first: bits 0..7 of `wr_data`, then, when `nine_mode`=1, the `wr_bit8` value captured with the write as the ninth bit.
- R3: When `par_en`=1, a parity bit follows the data. With `par_odd`=0 the count of ones over the data and parity bits is even. With `par_odd`=1 that count is odd.
- R4: The frame ends with one stop bit of value 1, or two when `two_stop`=1.
- R5: Every line bit, including each break bit, lasts exactly 16 cycles in which `baud_tick`=1. Cycles without a tick do not advance the line.
- R6: An accepted write drops `hold_empty` on the next cycle. `hold_empty` returns to 1 on the cycle after the held character moves into the shift stage, and that move happens in the first cycle where the shift stage is idle and `tx_en`=1.
- R7: A write while `hold_empty`=0 is ignored. The held character and what goes on the line are unchanged.
- R8: `tx_done` is 1 exactly when no frame or break is in flight, the holding register is empty and no break is pending. While it is 1, `txd` is 1.
- R9: A break drives `txd` to 0 for 10 bit times when `nine_mode`=0, and for 11 bit times when `nine_mode`=1, with no start or stop bit. The line then returns to 1.
- R10: A `brk_req` pulse is remembered. The break starts once the frame in flight has finished, and it goes ahead of a character waiting in the holding register.
- R11: While `tx_en`=0, no frame or break starts. A frame already in flight completes. Writes are still accepted, and both the held character and a pending break wait.
- R12: The format inputs are sampled when a frame or break starts. A change while a frame is in flight does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick enable, 16 per bit |
| tx_en | input | 1 | Allows new frames and breaks to start |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character bits 0..7 |
| wr_bit8 | input | 1 | Ninth data bit, captured with the write |
| nine_mode | input | 1 | 1 selects 9 data bits |
| par_en | input | 1 | 1 adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| brk_req | input | 1 | Pulse requesting one break character |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can take a write |
| tx_done | output | 1 | All output drained, line at rest |

## Verification
The assertions assume that `brk_req` and `wr_stb` are single-cycle pulses sampled on the clock. They also assume the format inputs are stable in the cycle a frame starts, so the sampled format is well defined.

The stimulus changes inputs only half a cycle away from the active edge. It changes format inputs only while the line is idle, except in the one case that tests mid-frame changes. It varies the tick spacing and pauses the tick, so that bit timing is checked against tick counts rather than clock counts.

A behavioural model that keeps the line as a queue of bits is compared with `txd` and both flags on every clock.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } tx_fmt_t;
endpackage

// File: rtl/tx_holdreg.sv
module tx_holdreg #(
  parameter int DW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [DW:0] wr_word,
  input  logic        take,
  output logic        full,
  output logic [DW:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (wr && !full) begin
        full <= 1'b1;
        word <= wr_word;
      end
    end
  end

  assert_take_empties_R6: assert property (@(posedge clk) disable iff (rst)
    (take && full) |=> !full);

  assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !take) |=> (full && $stable(word)));
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import async_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = DW + 5,
  parameter int LW = $clog2(FW + 1)
) (
  input  logic [DW:0]   word,
  input  tx_fmt_t       fmt,
  input  logic          is_brk,
  output logic [FW-1:0] frame,
  output logic [LW-1:0] flen
);
  logic          par;
  logic [LW-1:0] pos;
  logic [LW-1:0] brk_len;

  assign par     = (^word[DW-1:0]) ^ (fmt.nine & word[DW]) ^ fmt.par_odd;
  assign brk_len = fmt.nine ? LW'(DW + 3) : LW'(DW + 2);

  always_comb begin
    frame = '1;
    pos   = LW'(DW + 1);
    flen  = '0;
    if (is_brk) begin
      for (int i = 0; i < FW; i++)
        if (i < int'(brk_len)) frame[i] = 1'b0;
      flen = brk_len;
    end else begin
      frame[0] = 1'b0;
      for (int i = 0; i < DW; i++) frame[i+1] = word[i];
      if (fmt.nine) begin
        frame[pos] = word[DW];
        pos = pos + 1'b1;
      end
      if (fmt.par_en) begin
        frame[pos] = par;
        pos = pos + 1'b1;
      end
      flen = pos + (fmt.two_stop ? LW'(2) : LW'(1));
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int OSR = 16,
  parameter int FW  = 13,
  parameter int LW  = 4,
  localparam int CW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] flen,
  output logic          busy,
  output logic          txd
);
  logic [FW-1:0] shr;
  logic [LW-1:0] left;
  logic [CW-1:0] tcnt;
  logic          bit_end;

  assign bit_end = tick && (tcnt == CW'(OSR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      shr  <= '1;
      left <= '0;
      tcnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        shr  <= frame;
        txd  <= frame[0];
        left <= flen;
        tcnt <= '0;
      end
    end else if (tick) begin
      if (bit_end) begin
        tcnt <= '0;
        if (left == LW'(1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          left <= left - 1'b1;
          shr  <= {1'b1, shr[FW-1:1]};
          txd  <= shr[1];
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assert_line_rests_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  assert_first_bit_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);

  assert_bit_held_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_end) |=> (txd == $past(txd)));
endmodule

// File: rtl/async_tx_break.sv
module async_tx_break
  import async_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16,
  localparam int FW = DW + 5,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          tx_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_bit8,
  input  logic          nine_mode,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  input  logic          brk_req,
  output logic          txd,
  output logic          hold_empty,
  output logic          tx_done
);
  tx_fmt_t       fmt;
  logic          hold_full;
  logic [DW:0]   hold_word;
  logic          brk_pend;
  logic          busy;
  logic          start_brk;
  logic          start_dat;
  logic [FW-1:0] frame;
  logic [LW-1:0] flen;

  assign fmt = '{nine: nine_mode, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

  assign start_brk = tx_en && !busy && brk_pend;
  assign start_dat = tx_en && !busy && !brk_pend && hold_full;

  always_ff @(posedge clk) begin
    if (rst) brk_pend <= 1'b0;
    else     brk_pend <= (brk_pend && !start_brk) || brk_req;
  end

  tx_holdreg #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .wr(wr_stb), .wr_word({wr_bit8, wr_data}),
    .take(start_dat), .full(hold_full), .word(hold_word)
  );

  tx_framer #(.DW(DW), .FW(FW), .LW(LW)) u_frm (
    .word(hold_word), .fmt(fmt), .is_brk(brk_pend),
    .frame(frame), .flen(flen)
  );

  tx_shifter #(.OSR(OSR), .FW(FW), .LW(LW)) u_shf (
    .clk(clk), .rst(rst), .tick(baud_tick), .start(start_brk || start_dat),
    .frame(frame), .flen(flen), .busy(busy), .txd(txd)
  );

  assign hold_empty = !hold_full;
  assign tx_done    = !busy && !hold_full && !brk_pend;

  assert_done_line_high_R8: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> txd);

  assert_break_first_R10: assert property (@(posedge clk) disable iff (rst)
    (brk_pend && hold_full && !busy && tx_en) |=> (busy && hold_full));

  assert_no_start_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !busy) |=> !busy);
endmodule

// File: tb/async_tx_break_test.sv
`timescale 1ns/1ps
module async_tx_break_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0, tx_en = 1'b1, wr_stb = 1'b0, wr_bit8 = 1'b0;
  logic [7:0] wr_data = '0;
  logic nine_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, brk_req = 1'b0;
  logic txd, hold_empty, tx_done;

  always #2 clk = ~clk;

  async_tx_break uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .nine_mode(nine_mode), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .brk_req(brk_req),
    .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  int tdiv = 1, tphase = 0;

  // behavioural model: the line as a queue of bits
  bit m_full, m_pend, m_busy, m_txd, o_full, o_pend;
  bit [8:0] m_hold;
  int m_tcnt;
  bit q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_full = 0; m_pend = 0; m_busy = 0; m_txd = 1; m_tcnt = 0; q.delete();
    end else begin
      o_full = m_full; o_pend = m_pend;
      if (m_busy) begin
        if (baud_tick) begin
          if (m_tcnt == 15) begin
            m_tcnt = 0;
            void'(q.pop_front());
            if (q.size() == 0) begin m_busy = 0; m_txd = 1; end
            else m_txd = q[0];
          end else m_tcnt++;
        end
      end else if (tx_en && o_pend) begin
        q.delete();
        for (int i = 0; i < (nine_mode ? 11 : 10); i++) q.push_back(1'b0);
        m_busy = 1; m_tcnt = 0; m_txd = 0; m_pend = 0;
      end else if (tx_en && o_full) begin
        int ones;
        ones = 0;
        q.delete();
        q.push_back(1'b0);
        for (int i = 0; i < 8; i++) begin q.push_back(m_hold[i]); ones += m_hold[i]; end
        if (nine_mode) begin q.push_back(m_hold[8]); ones += m_hold[8]; end
        if (par_en) q.push_back(par_odd ? ~ones[0] : ones[0]);
        q.push_back(1'b1);
        if (two_stop) q.push_back(1'b1);
        m_busy = 1; m_tcnt = 0; m_txd = 0; m_full = 0;
      end
      if (wr_stb && !o_full) begin m_full = 1; m_hold = {wr_bit8, wr_data}; end
      if (brk_req) m_pend = 1;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(cur_req, "txd", txd, m_txd);
    chk(cur_req, "hold_empty", hold_empty, !m_full);
    chk(cur_req, "tx_done", tx_done, !m_busy && !m_full && !m_pend);
    wr_stb = 0;
    brk_req = 0;
    if (tdiv == 0) baud_tick = 0;
    else baud_tick = (tphase % tdiv) == 0;
    tphase++;
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic fmt(bit n9, bit pe, bit po, bit ts);
    nine_mode = n9; par_en = pe; par_odd = po; two_stop = ts;
  endtask

  task automatic send(bit [8:0] d);
    wr_stb = 1; wr_data = d[7:0]; wr_bit8 = d[8];
    step();
  endtask

  task automatic brk();
    brk_req = 1;
    step();
  endtask

  task automatic wait_done();
    step();
    while (!(!m_busy && !m_full && !m_pend)) step();
    run(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run(4);
    rst = 0;
    step();
    // R1: reset state
    chk("R1", "txd", txd, 1'b1);
    chk("R1", "hold_empty", hold_empty, 1'b1);
    chk("R1", "tx_done", tx_done, 1'b1);

    cur_req = "R2";  fmt(0, 0, 0, 0); send(9'h04A); wait_done();
    cur_req = "R3";  fmt(0, 1, 0, 1); send(9'h04A); wait_done();
    send(9'h0B4); wait_done();
    fmt(0, 1, 1, 1); send(9'h0B4); wait_done();
    cur_req = "R4";  fmt(0, 0, 0, 1); send(9'h00F); wait_done();
    fmt(0, 0, 0, 0); send(9'h0F0); wait_done();
    cur_req = "R2";  fmt(1, 1, 1, 1); send(9'h155); wait_done();
    fmt(1, 1, 0, 0); send(9'h0AA); wait_done();

    // R5: tick spacing and pauses
    cur_req = "R5"; fmt(0, 0, 0, 0); tdiv = 3; send(9'h0C3);
    run(40); tdiv = 0; run(50); tdiv = 2; wait_done();
    tdiv = 1;

    // R6: back-to-back characters through the holding register
    cur_req = "R6"; send(9'h011);
    while (m_full) step();
    send(9'h022);
    while (m_full) step();
    send(9'h033); wait_done();

    // R7: write while full is ignored
    cur_req = "R7"; send(9'h044); run(2); send(9'h055); send(9'h066); run(3); send(9'h077);
    wait_done();

    // R9: break length in both character modes
    cur_req = "R9"; fmt(0, 1, 0, 1); brk(); wait_done();
    fmt(1, 0, 0, 0); brk(); wait_done();

    // R10: break requested mid-frame goes before the held character
    cur_req = "R10"; fmt(0, 0, 0, 0); send(9'h081); run(3); send(9'h07E); run(20); brk();
    wait_done();

    // R11: disabled transmitter starts nothing
    cur_req = "R11"; tx_en = 0; send(9'h05A); brk(); run(300); tx_en = 1; wait_done();
    send(9'h0C0); run(30); tx_en = 0; run(200); send(9'h00C); run(50); tx_en = 1; wait_done();

    // R12: format sampled at frame start
    cur_req = "R12"; fmt(0, 0, 0, 0); send(9'h0A5); run(5); fmt(1, 1, 0, 1); send(9'h1FF);
    run(60); fmt(0, 0, 0, 0); wait_done();

    // R8: completion flag over a two-character burst
    cur_req = "R8"; fmt(0, 1, 1, 1); send(9'h03C); run(2); send(9'h0C3); wait_done();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule